// File: doc/BRIEF.md
# Coprocessor Null-Primitive Response Sequencer

This block runs on the host side of a host/coprocessor instruction dialogue. A new dialogue begins with a one-cycle start strobe that also carries the instruction category: general or conditional. Each time the host fetches the coprocessor's response register, the fetched word arrives with a valid strobe. The block decodes the word's flags and picks the next step. It can ask for another read of the response register. It can raise an interrupt-service request and wait until that service is reported complete. It can close a conditional instruction and report the condition outcome. It can close a general instruction.

For a general instruction, a pending trace changes when the dialogue may end. While trace is pending, the block keeps asking for re-reads until a null response arrives with come-again clear and processing-finished set. That response closes the dialogue and produces a one-cycle trace-start pulse. The bus transfers and every primitive type other than the null primitive belong to surrounding logic.

Top module: `cpnull_seq`

## Requirements
- R1: After reset, every output is low and the block is idle, waiting for a start strobe.
- R2: A response with come-again (bit 15) set and interrupts-allowed (bit 14) clear produces a single-cycle re-read request in the cycle after the valid strobe. No interrupt-service request is raised, even with an interrupt pending, and this holds for both categories.
- R3: A response with come-again and interrupts-allowed both set while an interrupt is pending raises the interrupt-service request in the cycle after the strobe. The request stays high, with no re-read, until interrupt-done is sampled high. In the following cycle the request drops and a single-cycle re-read request appears.
- R4: A response with come-again and interrupts-allowed set while no interrupt is pending is treated as a plain re-read (same timing as R2).
- R5: In a conditional instruction, a null response (function field bits 13:8 equal to NULL_CODE) with come-again clear produces done and condition-valid pulses in the cycle after the strobe. Condition-result then equals bit 0 (1 = true), and processing-finished (bit 1) and trace-pending have no effect.
- R6: In a general instruction with no trace pending, any response with come-again clear, whatever its function code, produces a done pulse with no condition-valid and no trace-start.
- R7: In a general instruction with trace pending, a come-again-clear response that is not a null response with processing-finished set does not end the dialogue. It is handled as in R2/R3 according to its interrupts-allowed bit. A null response with come-again clear and processing-finished set produces done and trace-start pulses together.
- R8: Done, condition-valid, trace-start and re-read are each high for exactly one clock. After done, the block returns to idle and accepts a new start.
- R9: Response strobes that arrive while idle or while waiting for interrupt-done cause no output change.
- R10: In a conditional instruction, a come-again-clear response that is not a null response ends the dialogue with a done pulse but no condition-valid.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begins a dialogue (sampled only while idle) |
| cond_cat_i | input | 1 | Category captured with start: 1 = conditional, 0 = general |
| trace_pend_i | input | 1 | Trace exception pending |
| irq_pend_i | input | 1 | Interrupt pending |
| irq_done_i | input | 1 | Interrupt service completed |
| resp_valid_i | input | 1 | Response word valid strobe |
| resp_word_i | input | WORD_W | Response register contents |
| reread_o | output | 1 | Request to read the response register again |
| irq_svc_o | output | 1 | Request to service pending interrupts |
| done_o | output | 1 | Dialogue finished pulse |
| cond_valid_o | output | 1 | Condition result valid pulse |
| cond_true_o | output | 1 | Condition result (1 = true), held until next result |
| trace_start_o | output | 1 | Start trace processing pulse |

## Verification
The bench builds the block with the default 16-bit word and bit positions, and overrides NULL_CODE to 5. Because of that override, the words with a zero function field that the bench sends are recognised as non-null. This exposes any decoder that ignores the parameter and separates the null-only paths of R5, R7 and R10 from the any-primitive path of R6. The default positions put both flag pairs at the word's extremes, so bit-slicing errors in the decoder show up in every scenario.

// File: rtl/cpnull_pkg.sv
package cpnull_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_SVC  = 2'd2,
        ST_DONE = 2'd3
    } cpn_state_e;

    typedef struct packed {
        logic is_null;
        logic ca;
        logic ia;
        logic pf;
        logic tf;
    } resp_flags_t;

    typedef struct packed {
        cpn_state_e st;
        logic       cond_cat;
        logic       reread;
        logic       svc;
        logic       done;
        logic       cval;
        logic       ctrue;
        logic       trc;
    } seq_regs_t;

endpackage

// File: rtl/cpnull_decode.sv
module cpnull_decode
    import cpnull_pkg::*;
#(
    parameter int unsigned WORD_W    = 16,
    parameter int unsigned CA_POS    = 15,
    parameter int unsigned IA_POS    = 14,
    parameter int unsigned FN_HI     = 13,
    parameter int unsigned FN_LO     = 8,
    parameter int unsigned PF_POS    = 1,
    parameter int unsigned TF_POS    = 0,
    parameter int unsigned NULL_CODE = 0
) (
    input  logic [WORD_W-1:0] word_i,
    output resp_flags_t       flags_o
);
    localparam int unsigned FN_W = FN_HI - FN_LO + 1;
    localparam logic [FN_W-1:0] NULL_FN = FN_W'(NULL_CODE);

    logic [FN_W-1:0] fn_field;
    logic            unused_rest;

    assign fn_field    = word_i[FN_HI:FN_LO];
    assign unused_rest = ^word_i;

    always_comb begin
        flags_o.is_null = (fn_field == NULL_FN);
        flags_o.ca      = word_i[CA_POS];
        flags_o.ia      = word_i[IA_POS];
        flags_o.pf      = word_i[PF_POS];
        flags_o.tf      = word_i[TF_POS];
    end

    initial begin
        assert (FN_HI >= FN_LO && FN_HI < WORD_W && CA_POS < WORD_W && IA_POS < WORD_W)
            else $error("cpnull_decode: field positions outside the word");
    end
endmodule

// File: rtl/cpnull_fsm.sv
module cpnull_fsm
    import cpnull_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start_i,
    input  logic        cond_cat_i,
    input  logic        trace_pend_i,
    input  logic        irq_pend_i,
    input  logic        irq_done_i,
    input  logic        resp_valid_i,
    input  resp_flags_t flags_i,
    output logic        reread_o,
    output logic        irq_svc_o,
    output logic        done_o,
    output logic        cond_valid_o,
    output logic        cond_true_o,
    output logic        trace_start_o
);
    seq_regs_t q, d;
    logic      go_on, finish;

    always_comb begin
        d        = q;
        d.reread = 1'b0;
        d.done   = 1'b0;
        d.cval   = 1'b0;
        d.trc    = 1'b0;
        go_on    = 1'b0;
        finish   = 1'b0;
        case (q.st)
            ST_IDLE: begin
                if (start_i) begin
                    d.st       = ST_WAIT;
                    d.cond_cat = cond_cat_i;
                end
            end
            ST_WAIT: begin
                if (resp_valid_i) begin
                    if (flags_i.ca) begin
                        go_on = 1'b1;
                    end else if (q.cond_cat) begin
                        finish = 1'b1;
                        if (flags_i.is_null) begin
                            d.cval  = 1'b1;
                            d.ctrue = flags_i.tf;
                        end
                    end else if (trace_pend_i) begin
                        if (flags_i.is_null && flags_i.pf) begin
                            finish = 1'b1;
                            d.trc  = 1'b1;
                        end else begin
                            go_on = 1'b1;
                        end
                    end else begin
                        finish = 1'b1;
                    end
                    if (go_on) begin
                        if (flags_i.ia && irq_pend_i) begin
                            d.st  = ST_SVC;
                            d.svc = 1'b1;
                        end else begin
                            d.reread = 1'b1;
                        end
                    end
                    if (finish) begin
                        d.st   = ST_DONE;
                        d.done = 1'b1;
                    end
                end
            end
            ST_SVC: begin
                if (irq_done_i) begin
                    d.svc    = 1'b0;
                    d.reread = 1'b1;
                    d.st     = ST_WAIT;
                end
            end
            ST_DONE: begin
                d.st = ST_IDLE;
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: ST_IDLE, default: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign reread_o      = q.reread;
    assign irq_svc_o     = q.svc;
    assign done_o        = q.done;
    assign cond_valid_o  = q.cval;
    assign cond_true_o   = q.ctrue;
    assign trace_start_o = q.trc;

    AST_PLAIN_REREAD: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_WAIT && resp_valid_i && flags_i.ca && !(flags_i.ia && irq_pend_i)) |=> (reread_o && !irq_svc_o)); // R2
    AST_SVC_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_WAIT && resp_valid_i && flags_i.ca && flags_i.ia && irq_pend_i) |=> (irq_svc_o && !reread_o)); // R3
    AST_SVC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_svc_o && !irq_done_i) |=> (irq_svc_o && !reread_o && !done_o)); // R3
    AST_SVC_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_svc_o && irq_done_i) |=> (reread_o && !irq_svc_o)); // R3
    AST_COND_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_WAIT && resp_valid_i && !flags_i.ca && q.cond_cat && flags_i.is_null)
        |=> (done_o && cond_valid_o && cond_true_o == $past(flags_i.tf))); // R5
    AST_GEN_END: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_WAIT && resp_valid_i && !flags_i.ca && !q.cond_cat && !trace_pend_i)
        |=> (done_o && !trace_start_o && !cond_valid_o)); // R6
    AST_TRACE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_WAIT && resp_valid_i && !q.cond_cat && trace_pend_i && !(flags_i.is_null && flags_i.pf))
        |=> !done_o); // R7
    AST_TRACE_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        trace_start_o |-> (done_o && !cond_valid_o)); // R7
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> (!done_o && !cond_valid_o && !trace_start_o)); // R8
    AST_ONE_ACTION: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({reread_o, irq_svc_o, done_o})); // R8
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_IDLE) |=> (!done_o && !reread_o && !irq_svc_o)); // R9
endmodule

// File: rtl/cpnull_seq.sv
module cpnull_seq
    import cpnull_pkg::*;
#(
    parameter int unsigned WORD_W    = 16,
    parameter int unsigned CA_POS    = 15,
    parameter int unsigned IA_POS    = 14,
    parameter int unsigned FN_HI     = 13,
    parameter int unsigned FN_LO     = 8,
    parameter int unsigned PF_POS    = 1,
    parameter int unsigned TF_POS    = 0,
    parameter int unsigned NULL_CODE = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              cond_cat_i,
    input  logic              trace_pend_i,
    input  logic              irq_pend_i,
    input  logic              irq_done_i,
    input  logic              resp_valid_i,
    input  logic [WORD_W-1:0] resp_word_i,
    output logic              reread_o,
    output logic              irq_svc_o,
    output logic              done_o,
    output logic              cond_valid_o,
    output logic              cond_true_o,
    output logic              trace_start_o
);
    resp_flags_t flags;

    cpnull_decode #(
        .WORD_W   (WORD_W),
        .CA_POS   (CA_POS),
        .IA_POS   (IA_POS),
        .FN_HI    (FN_HI),
        .FN_LO    (FN_LO),
        .PF_POS   (PF_POS),
        .TF_POS   (TF_POS),
        .NULL_CODE(NULL_CODE)
    ) u_decode (
        .word_i (resp_word_i),
        .flags_o(flags)
    );

    cpnull_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .cond_cat_i   (cond_cat_i),
        .trace_pend_i (trace_pend_i),
        .irq_pend_i   (irq_pend_i),
        .irq_done_i   (irq_done_i),
        .resp_valid_i (resp_valid_i),
        .flags_i      (flags),
        .reread_o     (reread_o),
        .irq_svc_o    (irq_svc_o),
        .done_o       (done_o),
        .cond_valid_o (cond_valid_o),
        .cond_true_o  (cond_true_o),
        .trace_start_o(trace_start_o)
    );
endmodule

// File: tb/cpnull_seq_test.sv
`timescale 1ns/1ps
module cpnull_seq_test;
    localparam int unsigned NC = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0, cond_cat_i = 1'b0, trace_pend_i = 1'b0;
    logic        irq_pend_i = 1'b0, irq_done_i = 1'b0, resp_valid_i = 1'b0;
    logic [15:0] resp_word_i = '0;
    logic        reread_o, irq_svc_o, done_o, cond_valid_o, cond_true_o, trace_start_o;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    cpnull_seq #(.NULL_CODE(NC)) uut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .cond_cat_i(cond_cat_i),
        .trace_pend_i(trace_pend_i), .irq_pend_i(irq_pend_i), .irq_done_i(irq_done_i),
        .resp_valid_i(resp_valid_i), .resp_word_i(resp_word_i),
        .reread_o(reread_o), .irq_svc_o(irq_svc_o), .done_o(done_o),
        .cond_valid_o(cond_valid_o), .cond_true_o(cond_true_o), .trace_start_o(trace_start_o)
    );

    function automatic logic [15:0] mk(input logic ca, input logic ia, input logic [5:0] fn,
                                       input logic pf, input logic tf);
        return {ca, ia, fn, 6'b0, pf, tf};
    endfunction

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    // checks all pulse/level outputs at once (cond_true excluded)
    task automatic chk_out(input string req, input logic rr, input logic sv, input logic dn,
                           input logic cv, input logic tr);
        chk(req, "reread", reread_o, rr);
        chk(req, "irq_svc", irq_svc_o, sv);
        chk(req, "done", done_o, dn);
        chk(req, "cond_valid", cond_valid_o, cv);
        chk(req, "trace_start", trace_start_o, tr);
    endtask

    task automatic begin_instr(input logic cat);
        @(negedge clk);
        start_i = 1'b1; cond_cat_i = cat;
        @(negedge clk);
        start_i = 1'b0; cond_cat_i = 1'b0;
    endtask

    task automatic send(input logic [15:0] w);
        resp_valid_i = 1'b1; resp_word_i = w;
        @(negedge clk);
        resp_valid_i = 1'b0; resp_word_i = '0;
    endtask

    task automatic finish_general();
        send(mk(1'b0, 1'b0, 6'(NC), 1'b1, 1'b0));
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset();
        chk_out("R1", 0, 0, 0, 0, 0);
        chk("R1", "cond_true", cond_true_o, 1'b0);
    endtask

    task automatic t_plain_reread();
        irq_pend_i = 1'b1;
        begin_instr(1'b0);
        send(mk(1'b1, 1'b0, 6'(NC), 1'b0, 1'b0));
        chk_out("R2", 1, 0, 0, 0, 0);
        @(negedge clk);
        chk_out("R8", 0, 0, 0, 0, 0);
        finish_general();
        begin_instr(1'b1);
        send(mk(1'b1, 1'b0, 6'(NC), 1'b1, 1'b1));
        chk_out("R2", 1, 0, 0, 0, 0);
        send(mk(1'b0, 1'b0, 6'(NC), 1'b0, 1'b0));
        @(negedge clk);
        @(negedge clk);
        irq_pend_i = 1'b0;
    endtask

    task automatic t_service();
        irq_pend_i = 1'b1;
        begin_instr(1'b0);
        send(mk(1'b1, 1'b1, 6'(NC), 1'b0, 1'b0));
        chk_out("R3", 0, 1, 0, 0, 0);
        repeat (3) @(negedge clk);
        chk_out("R3", 0, 1, 0, 0, 0);
        // response strobe while servicing is ignored
        send(mk(1'b0, 1'b0, 6'(NC), 1'b1, 1'b0));
        chk_out("R9", 0, 1, 0, 0, 0);
        irq_done_i = 1'b1;
        @(negedge clk);
        irq_done_i = 1'b0;
        chk_out("R3", 1, 0, 0, 0, 0);
        @(negedge clk);
        chk_out("R8", 0, 0, 0, 0, 0);
        irq_pend_i = 1'b0;
        finish_general();
    endtask

    task automatic t_ia_no_irq();
        begin_instr(1'b0);
        send(mk(1'b1, 1'b1, 6'(NC), 1'b0, 1'b0));
        chk_out("R4", 1, 0, 0, 0, 0);
        @(negedge clk);
        chk_out("R4", 0, 0, 0, 0, 0);
        finish_general();
    endtask

    task automatic t_conditional();
        begin_instr(1'b1);
        send(mk(1'b0, 1'b0, 6'(NC), 1'b0, 1'b1));
        chk_out("R5", 0, 0, 1, 1, 0);
        chk("R5", "cond_true", cond_true_o, 1'b1);
        @(negedge clk);
        chk_out("R8", 0, 0, 0, 0, 0);
        trace_pend_i = 1'b1;
        begin_instr(1'b1);
        send(mk(1'b0, 1'b0, 6'(NC), 1'b1, 1'b0));
        chk_out("R5", 0, 0, 1, 1, 0);
        chk("R5", "cond_true", cond_true_o, 1'b0);
        trace_pend_i = 1'b0;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic t_cond_nonnull();
        begin_instr(1'b1);
        send(mk(1'b0, 1'b0, 6'h00, 1'b0, 1'b1));
        chk_out("R10", 0, 0, 1, 0, 0);
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic t_general();
        begin_instr(1'b0);
        send(mk(1'b0, 1'b1, 6'h11, 1'b0, 1'b1));
        chk_out("R6", 0, 0, 1, 0, 0);
        @(negedge clk);
        chk_out("R8", 0, 0, 0, 0, 0);
        @(negedge clk);
        begin_instr(1'b0);
        send(mk(1'b0, 1'b0, 6'(NC), 1'b0, 1'b0));
        chk_out("R6", 0, 0, 1, 0, 0);
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic t_trace();
        trace_pend_i = 1'b1;
        begin_instr(1'b0);
        send(mk(1'b0, 1'b0, 6'(NC), 1'b0, 1'b0));
        chk_out("R7", 1, 0, 0, 0, 0);
        send(mk(1'b0, 1'b0, 6'h00, 1'b1, 1'b0));
        chk_out("R7", 1, 0, 0, 0, 0);
        irq_pend_i = 1'b1;
        send(mk(1'b0, 1'b1, 6'(NC), 1'b0, 1'b0));
        chk_out("R7", 0, 1, 0, 0, 0);
        irq_done_i = 1'b1;
        @(negedge clk);
        irq_done_i = 1'b0;
        irq_pend_i = 1'b0;
        chk_out("R7", 1, 0, 0, 0, 0);
        send(mk(1'b0, 1'b0, 6'(NC), 1'b1, 1'b0));
        chk_out("R7", 0, 0, 1, 0, 1);
        @(negedge clk);
        chk_out("R8", 0, 0, 0, 0, 0);
        trace_pend_i = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_idle_ignore();
        @(negedge clk);
        send(mk(1'b0, 1'b0, 6'(NC), 1'b1, 1'b1));
        chk_out("R9", 0, 0, 0, 0, 0);
        @(negedge clk);
        chk_out("R9", 0, 0, 0, 0, 0);
        // block is still idle: a fresh dialogue behaves normally
        begin_instr(1'b0);
        send(mk(1'b1, 1'b0, 6'(NC), 1'b0, 1'b0));
        chk_out("R9", 1, 0, 0, 0, 0);
        finish_general();
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_plain_reread();
        t_service();
        t_ia_no_irq();
        t_conditional();
        t_cond_nonnull();
        t_general();
        t_trace();
        t_idle_ignore();
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule